// File: doc/BRIEF.md
# I2C Bit-Timing Generator

This block derives the serial clock of an I2C master from the core clock. A programmable divider sets the clock period, and that period is always even. Each period is split into a phase where the block pulls the clock line low and a phase where it releases the line. A byte engine next to the block asks for clock periods by holding a run request. It receives two single-cycle strobes. One strobe marks when the next data bit should be put on SDA, a set number of core clocks after the block starts pulling the clock low. The other marks when SDA should be sampled, a set number of core clocks after the clock line is seen high.

The block reads the real level of the clock line back. A target that holds the line low after release therefore stretches the high phase. If the stretch lasts too long, the block raises a one-cycle timeout pulse. It then stops clocking and leaves the line released until it is disabled. Start and stop conditions and the data shift register are handled elsewhere.

Top module: `i2cSclTiming`

## Requirements
- R1: The clock period is 2*floor(divValue/2) core clocks, so bit 0 of the divider is ignored. A divider value of 0 or 1 behaves as 2. With no stretching, sclDriveLow is high for half the period and low for the other half.
- R2: driveStrobe is high for exactly one cycle, D core clocks after the cycle in which sclDriveLow goes high. D is the falling-edge delay in delayWord bits 31:16.
- R3: sampleStrobe is high for exactly one cycle, R core clocks after the first cycle of the release phase in which sclIn reads high. R is the rising-edge delay in delayWord bits 15:0.
- R4: A delay field of 0 acts as 1. A delay field larger than half the period acts as half the period.
- R5: During the release phase only cycles with sclIn high count toward its length. sclDriveLow never rises while the line is released and sclIn reads low.
- R6: Suppose sclIn stays low from the first release cycle onward and timeoutCount is N, not zero. Then timeoutPulse is high for one cycle, exactly N*period core clocks after sclDriveLow falls. When timeoutCount is 0, timeoutPulse never fires.
- R7: After a timeout, sclDriveLow stays low and neither strobe fires, whatever sclIn does, until enable is dropped. After re-enabling, clocking resumes.
- R8: A new period starts only when the block is idle, runReq is high and sclIn is high. If runReq is low at the end of a release phase, the period in progress completes and the line then stays released with no strobes. Raising runReq again starts a low phase on the next cycle.
- R9: While enable is low, sclDriveLow and all strobes are low and every counter is cleared. After re-enabling, the first low phase has its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low releases the line and clears all state |
| runReq | input | 1 | Run/hold request from the byte engine |
| divValue | input | DIV_W | Clock divider; bit 0 ignored |
| delayWord | input | 2*DLY_W | Falling-edge delay in the upper half, rising-edge delay in the lower half |
| timeoutCount | input | TO_W | Stretch limit in clock periods; 0 disables the limit |
| sclIn | input | 1 | Sampled level of the clock line |
| sclDriveLow | output | 1 | High pulls the clock line low |
| driveStrobe | output | 1 | One-cycle mark to put the next SDA bit on the line |
| sampleStrobe | output | 1 | One-cycle mark to sample SDA |
| timeoutPulse | output | 1 | One-cycle mark that the stretch limit expired |

## Verification
The bench measures the low-phase length, the high-phase length and the strobe offsets over one period for a set of dividers. The set includes odd values, 1 and 2, and delays of 0 and delays above half the period. A design that kept the divider's bit 0 would produce an odd period, and one that skipped clamping would never fire a strobe at all. A target stretches the clock for a fixed number of cycles. A design whose release phase counted wall time instead of line-high time would shorten the high phase and sample too early. The timeout is checked for its exact cycle, its one-cycle width and the silent state that follows it, and a zero limit is held against a long stretch. Run-drop and disable-mid-phase checks catch a design that cuts a phase short or keeps a stale count.

// File: rtl/i2cSclTimingPkg.sv
package i2cSclTimingPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_TRIP = 2'd3
  } tmgState_t;

  // control -> datapath
  typedef struct packed {
    logic phaseClr;
    logic phaseInc;
    logic stretchClr;
    logic stretchInc;
  } tmgCmd_t;

  // datapath -> control
  typedef struct packed {
    logic phaseEnd;
    logic driveHit;
    logic sampleHit;
    logic stretchExpire;
  } tmgFlag_t;

endpackage

// File: rtl/i2cSclTimingDp.sv
module i2cSclTimingDp
  import i2cSclTimingPkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DLY_W = 16,
  parameter int TO_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [DIV_W-1:0]   divValue,
  input  logic [2*DLY_W-1:0] delayWord,
  input  logic [TO_W-1:0]    timeoutCount,
  input  tmgCmd_t            cmd,
  output tmgFlag_t           flag
);

  localparam int HALF_W = DIV_W - 1;
  localparam int CMP_W  = (DLY_W > HALF_W) ? DLY_W : HALF_W;

  logic [HALF_W-1:0] halfVal;
  logic [DIV_W-1:0]  periodVal;
  logic [HALF_W-1:0] phaseCnt;
  logic [DIV_W-1:0]  subCnt;
  logic [TO_W-1:0]   cycCnt;
  logic              subLast;

  // bit 0 of the divider is dropped; a zero half becomes one
  always_comb begin
    if (divValue[DIV_W-1:1] == '0) halfVal = HALF_W'(1);
    else                           halfVal = divValue[DIV_W-1:1];
  end
  assign periodVal = {halfVal, 1'b0};

  // index 0: rising-edge delay (low field), index 1: falling-edge delay
  for (genvar g = 0; g < 2; g++) begin : gClamp
    logic [DLY_W-1:0]  raw;
    logic [HALF_W-1:0] eff;
    assign raw = delayWord[g*DLY_W +: DLY_W];
    always_comb begin
      if (raw == '0)                            eff = HALF_W'(1);
      else if (CMP_W'(raw) > CMP_W'(halfVal))   eff = halfVal;
      else                                      eff = HALF_W'(raw);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      subCnt   <= '0;
      cycCnt   <= '0;
    end else if (!enable) begin
      phaseCnt <= '0;
      subCnt   <= '0;
      cycCnt   <= '0;
    end else begin
      if (cmd.phaseClr)      phaseCnt <= '0;
      else if (cmd.phaseInc) phaseCnt <= phaseCnt + 1'b1;

      if (cmd.stretchClr) begin
        subCnt <= '0;
        cycCnt <= '0;
      end else if (cmd.stretchInc) begin
        if (subLast) begin
          subCnt <= '0;
          cycCnt <= cycCnt + 1'b1;
        end else begin
          subCnt <= subCnt + 1'b1;
        end
      end
    end
  end

  assign subLast = (subCnt == periodVal - 1'b1);

  always_comb begin
    flag.phaseEnd      = (phaseCnt == halfVal - 1'b1);
    flag.driveHit      = (phaseCnt == gClamp[1].eff - 1'b1);
    flag.sampleHit     = (phaseCnt == gClamp[0].eff - 1'b1);
    flag.stretchExpire = (timeoutCount != '0) && subLast &&
                         (cycCnt == timeoutCount - 1'b1);
  end

endmodule

// File: rtl/i2cSclTimingCtrl.sv
module i2cSclTimingCtrl
  import i2cSclTimingPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     runReq,
  input  logic     sclIn,
  input  tmgFlag_t flag,
  output tmgCmd_t  cmd,
  output logic     sclDriveLow,
  output logic     driveStrobe,
  output logic     sampleStrobe,
  output logic     timeoutPulse
);

  tmgState_t state, nextState;

  always_comb begin
    nextState = state;
    cmd       = '0;
    case (state)
      ST_IDLE: begin
        cmd.phaseClr   = 1'b1;
        cmd.stretchClr = 1'b1;
        if (runReq && sclIn) nextState = ST_LOW;
      end
      ST_LOW: begin
        if (flag.phaseEnd) begin
          nextState      = ST_HIGH;
          cmd.phaseClr   = 1'b1;
          cmd.stretchClr = 1'b1;
        end else begin
          cmd.phaseInc = 1'b1;
        end
      end
      ST_HIGH: begin
        if (sclIn) begin
          cmd.stretchClr = 1'b1;
          if (flag.phaseEnd) begin
            cmd.phaseClr = 1'b1;
            nextState    = runReq ? ST_LOW : ST_IDLE;
          end else begin
            cmd.phaseInc = 1'b1;
          end
        end else if (flag.stretchExpire) begin
          nextState = ST_TRIP;
        end else begin
          cmd.stretchInc = 1'b1;
        end
      end
      ST_TRIP: nextState = ST_TRIP;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      sclDriveLow  <= 1'b0;
      driveStrobe  <= 1'b0;
      sampleStrobe <= 1'b0;
      timeoutPulse <= 1'b0;
    end else if (!enable) begin
      state        <= ST_IDLE;
      sclDriveLow  <= 1'b0;
      driveStrobe  <= 1'b0;
      sampleStrobe <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      state        <= nextState;
      sclDriveLow  <= (nextState == ST_LOW);
      driveStrobe  <= (state == ST_LOW) && flag.driveHit;
      sampleStrobe <= (state == ST_HIGH) && sclIn && flag.sampleHit;
      timeoutPulse <= (state == ST_HIGH) && !sclIn && flag.stretchExpire;
    end
  end

endmodule

// File: rtl/i2cSclTiming.sv
module i2cSclTiming
  import i2cSclTimingPkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DLY_W = 16,
  parameter int TO_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               runReq,
  input  logic [DIV_W-1:0]   divValue,
  input  logic [2*DLY_W-1:0] delayWord,
  input  logic [TO_W-1:0]    timeoutCount,
  input  logic               sclIn,
  output logic               sclDriveLow,
  output logic               driveStrobe,
  output logic               sampleStrobe,
  output logic               timeoutPulse
);

  tmgCmd_t  cmd;
  tmgFlag_t flag;

  i2cSclTimingDp #(.DIV_W(DIV_W), .DLY_W(DLY_W), .TO_W(TO_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .divValue     (divValue),
    .delayWord    (delayWord),
    .timeoutCount (timeoutCount),
    .cmd          (cmd),
    .flag         (flag)
  );

  i2cSclTimingCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .runReq       (runReq),
    .sclIn        (sclIn),
    .flag         (flag),
    .cmd          (cmd),
    .sclDriveLow  (sclDriveLow),
    .driveStrobe  (driveStrobe),
    .sampleStrobe (sampleStrobe),
    .timeoutPulse (timeoutPulse)
  );

endmodule

// File: rtl/i2cSclTimingChecker.sv
module i2cSclTimingChecker #(
  parameter int TO_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            enable,
  input logic [TO_W-1:0] timeoutCount,
  input logic            sclIn,
  input logic            sclDriveLow,
  input logic            driveStrobe,
  input logic            sampleStrobe,
  input logic            timeoutPulse
);

  logic tripped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tripped <= 1'b0;
    else if (!enable)      tripped <= 1'b0;
    else if (timeoutPulse) tripped <= 1'b1;
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !driveStrobe && !sampleStrobe && !timeoutPulse)); // R9

  AST_DRIVE_IN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    driveStrobe |-> $past(sclDriveLow)); // R2

  AST_SAMPLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> $past(!sclDriveLow && sclIn)); // R3

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !sclDriveLow && !sclIn) |=> !sclDriveLow); // R5

  AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse); // R6

  AST_TIMEOUT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (enable && timeoutCount == '0) |=> !timeoutPulse); // R6

  AST_TRIP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    tripped |-> (!sclDriveLow && !driveStrobe && !sampleStrobe)); // R7

endmodule

bind i2cSclTiming i2cSclTimingChecker #(.TO_W(TO_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .timeoutCount (timeoutCount),
  .sclIn        (sclIn),
  .sclDriveLow  (sclDriveLow),
  .driveStrobe  (driveStrobe),
  .sampleStrobe (sampleStrobe),
  .timeoutPulse (timeoutPulse)
);

// File: tb/i2cSclTiming_bench.sv
module i2cSclTiming_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [15:0] div;
    logic [15:0] fall;
    logic [15:0] rise;
    int          expHalf;
    int          expD;
    int          expR;
    logic        clampCase;
  } vec_t;

  // div, fall delay, rise delay, expected half, drive offset, sample offset
  localparam vec_t VECS [NVEC] = '{
    '{16'd8,  16'd1,  16'd2,  4,  1,  2,  1'b0},
    '{16'd9,  16'd3,  16'd4,  4,  3,  4,  1'b0},
    '{16'd2,  16'd0,  16'd0,  1,  1,  1,  1'b1},
    '{16'd20, 16'd50, 16'd7,  10, 10, 7,  1'b1},
    '{16'd1,  16'd5,  16'd5,  1,  1,  1,  1'b1},
    '{16'd33, 16'd2,  16'd16, 16, 2,  16, 1'b0}
  };

  logic        clk;
  logic        rstN;
  logic        enable;
  logic        runReq;
  logic [15:0] divValue;
  logic [31:0] delayWord;
  logic [15:0] timeoutCount;
  logic        slaveHold;
  logic        sclIn;
  logic        sclDriveLow;
  logic        driveStrobe;
  logic        sampleStrobe;
  logic        timeoutPulse;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  assign sclIn = !sclDriveLow && !slaveHold;

  i2cSclTiming u_i2cSclTiming (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .runReq       (runReq),
    .divValue     (divValue),
    .delayWord    (delayWord),
    .timeoutCount (timeoutCount),
    .sclIn        (sclIn),
    .sclDriveLow  (sclDriveLow),
    .driveStrobe  (driveStrobe),
    .sampleStrobe (sampleStrobe),
    .timeoutPulse (timeoutPulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic configure(input logic [15:0] dv, input logic [15:0] fd,
                           input logic [15:0] rd, input logic [15:0] to);
    @(negedge clk);
    enable = 1'b0;
    runReq = 1'b0;
    slaveHold = 1'b0;
    divValue = dv;
    delayWord = {fd, rd};
    timeoutCount = to;
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
    runReq = 1'b1;
    @(negedge clk);
  endtask

  // Waits for a low phase, then measures one full period.
  task automatic measure(input int holdCyc, output int lowLen, output int highLen,
                         output int drvOff, output int smpOff);
    int k;
    int rel;
    int nxt;
    drvOff = -1;
    smpOff = -1;
    rel = -1;
    nxt = -1;
    for (int w = 0; w < 200 && !sclDriveLow; w++) @(negedge clk);
    k = 0;
    while (nxt < 0 && k < 2000) begin
      if (driveStrobe && drvOff < 0) drvOff = k;
      if (rel < 0 && !sclDriveLow) begin
        rel = k;
        if (holdCyc > 0) slaveHold = 1'b1;
      end
      if (rel >= 0 && holdCyc > 0 && k == rel + holdCyc) slaveHold = 1'b0;
      if (rel >= 0 && sampleStrobe && smpOff < 0) smpOff = k - rel;
      if (rel >= 0 && k > rel && sclDriveLow) nxt = k;
      if (nxt < 0) begin
        @(negedge clk);
        k++;
      end
    end
    lowLen = rel;
    highLen = nxt - rel;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lowLen;
    int highLen;
    int drvOff;
    int smpOff;
    int pulseAt;
    int pulseCnt;
    int lowsSeen;
    int strobesSeen;
    int found;

    rstN = 1'b0;
    enable = 1'b0;
    runReq = 1'b0;
    slaveHold = 1'b0;
    divValue = 16'd8;
    delayWord = '0;
    timeoutCount = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9: reset / disabled state
    check(!sclDriveLow && !driveStrobe && !sampleStrobe && !timeoutPulse,
          "R9 outputs quiet while disabled", int'(sclDriveLow), 0);

    // Table of dividers and delays: R1 R2 R3 R4
    for (int v = 0; v < NVEC; v++) begin
      configure(VECS[v].div, VECS[v].fall, VECS[v].rise, 16'd0);
      measure(0, lowLen, highLen, drvOff, smpOff);
      check(lowLen == VECS[v].expHalf, "R1 low phase length", lowLen, VECS[v].expHalf);
      check(highLen == VECS[v].expHalf, "R1 high phase length", highLen, VECS[v].expHalf);
      check(drvOff == VECS[v].expD, VECS[v].clampCase ? "R4 drive offset" : "R2 drive offset",
            drvOff, VECS[v].expD);
      check(smpOff == VECS[v].expR, VECS[v].clampCase ? "R4 sample offset" : "R3 sample offset",
            smpOff, VECS[v].expR);
    end

    // R5: target stretches the release phase for 5 cycles
    configure(16'd8, 16'd1, 16'd2, 16'd0);
    measure(5, lowLen, highLen, drvOff, smpOff);
    check(lowLen == 4, "R5 low length with stretch", lowLen, 4);
    check(highLen == 9, "R5 stretched high length", highLen, 9);
    check(smpOff == 7, "R5 sample after stretch", smpOff, 7);

    // R6 + R7: permanent stretch with a limit of 3 periods (24 clocks)
    configure(16'd8, 16'd1, 16'd2, 16'd3);
    for (int w = 0; w < 200 && !sclDriveLow; w++) @(negedge clk);
    for (int w = 0; w < 200 && sclDriveLow; w++) @(negedge clk);
    slaveHold = 1'b1;
    pulseAt = -1;
    pulseCnt = 0;
    lowsSeen = 0;
    strobesSeen = 0;
    for (int j = 0; j < 60; j++) begin
      if (timeoutPulse) begin
        pulseCnt++;
        if (pulseAt < 0) pulseAt = j;
      end
      if (pulseAt >= 0 && j > pulseAt) begin
        if (sclDriveLow) lowsSeen++;
        if (driveStrobe || sampleStrobe) strobesSeen++;
      end
      if (j == 40) slaveHold = 1'b0;
      @(negedge clk);
    end
    check(pulseAt == 24, "R6 timeout cycle", pulseAt, 24);
    check(pulseCnt == 1, "R6 timeout pulse width", pulseCnt, 1);
    check(lowsSeen == 0, "R7 line released after timeout", lowsSeen, 0);
    check(strobesSeen == 0, "R7 no strobes after timeout", strobesSeen, 0);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
    found = 0;
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      if (sclDriveLow) found = 1;
    end
    check(found == 1, "R7 clocking resumes after re-enable", found, 1);

    // R6: zero limit never times out; R5: no low while stretched
    configure(16'd8, 16'd1, 16'd2, 16'd0);
    for (int w = 0; w < 200 && !sclDriveLow; w++) @(negedge clk);
    for (int w = 0; w < 200 && sclDriveLow; w++) @(negedge clk);
    slaveHold = 1'b1;
    pulseCnt = 0;
    lowsSeen = 0;
    for (int j = 0; j < 60; j++) begin
      if (timeoutPulse) pulseCnt++;
      if (sclDriveLow) lowsSeen++;
      @(negedge clk);
    end
    slaveHold = 1'b0;
    check(pulseCnt == 0, "R6 zero limit never fires", pulseCnt, 0);
    check(lowsSeen == 0, "R5 no drive-low during stretch", lowsSeen, 0);
    found = -1;
    for (int j = 0; j < 10 && found < 0; j++) begin
      if (sclDriveLow) found = j;
      @(negedge clk);
    end
    check(found == 4, "R5 high phase resumes after line release", found, 4);

    // R8: run dropped at the start of a low phase
    configure(16'd8, 16'd1, 16'd2, 16'd0);
    for (int w = 0; w < 200 && !sclDriveLow; w++) @(negedge clk);
    runReq = 1'b0;
    lowLen = 0;
    while (sclDriveLow && lowLen < 100) begin
      @(negedge clk);
      lowLen++;
    end
    check(lowLen == 4, "R8 low phase completes after run drop", lowLen, 4);
    lowsSeen = 0;
    strobesSeen = 0;
    smpOff = -1;
    for (int j = 0; j < 30; j++) begin
      if (sclDriveLow) lowsSeen++;
      if (driveStrobe) strobesSeen++;
      if (sampleStrobe && smpOff < 0) smpOff = j;
      @(negedge clk);
    end
    check(smpOff == 2, "R8 final high phase still samples", smpOff, 2);
    check(lowsSeen == 0 && strobesSeen == 0, "R8 idle after run drop",
          lowsSeen + strobesSeen, 0);
    runReq = 1'b1;
    @(negedge clk);
    check(sclDriveLow == 1'b1, "R8 restart on run", int'(sclDriveLow), 1);

    // R9: disable in the middle of a low phase
    configure(16'd8, 16'd1, 16'd2, 16'd0);
    for (int w = 0; w < 200 && !sclDriveLow; w++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!sclDriveLow, "R9 disable releases line", int'(sclDriveLow), 0);
    repeat (3) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    measure(0, lowLen, highLen, drvOff, smpOff);
    check(lowLen == 4, "R9 fresh low phase after re-enable", lowLen, 4);
    check(drvOff == 1, "R9 drive offset after re-enable", drvOff, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule